// File: doc/BRIEF.md
# Selectable Pin Event Detector

This block watches one input out of a bank of pins and raises a sticky event flag when a programmed condition is seen on it. A configuration word picks both the pin and the condition. The conditions are rising edge, falling edge, any change, low level and high level; a disable code turns detection off. Every pin passes through a two-stage synchroniser before it reaches the detector. Edges are found by comparing the current synchronised sample with the one taken a cycle earlier.

Software or a sequencer clears the flag with a one-cycle clear pulse. Level conditions arm again as soon as they are cleared, so a held level reports again one cycle later. Edge conditions report once per transition. A sequencer that wants to stall until the event holds a wait request high. The block answers with a ready pulse in the cycle after the flag sets, and it clears the flag automatically at that same moment.

Top module: `pin_event_detector`

## Requirements
- R1: The configuration word is {mode[2:0], pin[5:0]}: mode in bits 8..6, pin index in bits 5..0. A configuration write clears the flag and the ready output in the next cycle. The first sample of the newly selected pin is only recorded and never counts as an edge, so switching to a pin that is already high in rising mode raises no event.
- R2: A change on the selected pin reaches the flag three rising clock edges after it is driven: two synchroniser edges, then the flag register.
- R3: Mode 001 sets the flag on a low-to-high transition of the selected pin.
- R4: Mode 010 sets the flag on a high-to-low transition of the selected pin.
- R5: Mode 011 sets the flag on either transition of the selected pin.
- R6: Modes 100 and 101 set the flag while the selected pin is low; mode bit 0 has no effect.
- R7: Modes 110 and 111 set the flag while the selected pin is high; mode bit 0 has no effect.
- R8: Mode 000 never sets the flag, whatever the pins do.
- R9: The flag stays set until a clear. A clear always drops it for at least one cycle, even while a level condition holds. If the level is still present it sets again on the next edge, giving the pattern set, clear, set.
- R10: An edge condition fires once per transition and does not fire again on a held level after a clear. An edge that is detected in the same cycle as a clear pulse is kept.
- R11: While wait_req_i is high, wait_ready_o pulses high in the cycle after the flag becomes set, and the flag is cleared at that same clock edge. While wait_req_i is low, the flag stays set and wait_ready_o stays low.
- R12: Pins other than the selected one have no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| pins_i | input | 64 | Pin bank (asynchronous to clk) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_i | input | 9 | Configuration word {mode, pin index} |
| clr_i | input | 1 | Flag clear pulse |
| wait_req_i | input | 1 | Sequencer is stalled waiting for the event |
| event_o | output | 1 | Sticky event flag |
| wait_ready_o | output | 1 | Releases the waiting sequencer for one cycle |

## Verification
Two functions can act on the flag in the same cycle: a clear and a new detection. The bench provokes this in two ways. It holds a high level in level mode and pulses a clear, then checks the flag at every negative edge for the exact set, clear, set pattern. It also times a clear pulse so that it lands in the cycle where a rising edge is being detected, and expects the flag to survive. The automatic clear on ready is likewise checked against the flag and ready values cycle by cycle.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_OFF    = 3'b000;
  localparam logic [MODE_W-1:0] MODE_RISE   = 3'b001;
  localparam logic [MODE_W-1:0] MODE_FALL   = 3'b010;
  localparam logic [MODE_W-1:0] MODE_CHANGE = 3'b011;

  // Level modes: bit 2 set, bit 1 is the level that triggers, bit 0 unused.
  function automatic logic is_level_mode(input logic [MODE_W-1:0] m);
    return m[2];
  endfunction

  function automatic logic level_match(input logic [MODE_W-1:0] m, input logic v);
    return m[2] && (v == m[1]);
  endfunction
endpackage

// File: rtl/pin_sync_bank.sv
module pin_sync_bank #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = async_i;
      end else begin : g_rest
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pin_select.sv
module pin_select #(
  parameter int WIDTH = 64,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] bank_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             bit_o
);
  always_comb begin
    bit_o = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      if (idx_i == IDX_W'(i)) bit_o = bank_i[i];
    end
  end
endmodule

// File: rtl/event_core.sv
module event_core
  import pin_event_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we_i,
  input  logic [MODE_W-1:0] cfg_mode_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              sample_i,
  input  logic              clr_i,
  input  logic              wait_req_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              flag_o,
  output logic              ready_o
);
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              prev_q, prev_d;
  logic              armed_q, armed_d;
  logic              flag_q, flag_d;
  logic              ready_q, ready_d;
  logic              edge_hit, level_hit;

  // Detection
  always_comb begin
    unique case (mode_q)
      MODE_RISE:   edge_hit = sample_i & ~prev_q;
      MODE_FALL:   edge_hit = ~sample_i & prev_q;
      MODE_CHANGE: edge_hit = sample_i ^ prev_q;
      default:     edge_hit = 1'b0;
    endcase
    edge_hit  = edge_hit & armed_q;
    level_hit = level_match(mode_q, sample_i);
  end

  // Next state
  always_comb begin
    mode_d  = mode_q;
    idx_d   = idx_q;
    prev_d  = sample_i;
    armed_d = 1'b1;
    ready_d = wait_req_i & flag_q;
    // a set edge survives any clear; a level or held flag yields to it
    flag_d  = edge_hit | ((flag_q | level_hit) & ~clr_i & ~ready_d);
    if (cfg_we_i) begin
      mode_d  = cfg_mode_i;
      idx_d   = cfg_idx_i;
      armed_d = 1'b0;
      ready_d = 1'b0;
      flag_d  = 1'b0;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_OFF;
      idx_q   <= '0;
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      if (cfg_we_i) begin
        mode_q <= mode_d;
        idx_q  <= idx_d;
      end
      prev_q  <= prev_d;
      armed_q <= armed_d;
      flag_q  <= flag_d;
      ready_q <= ready_d;
    end
  end

  assign idx_o   = idx_q;
  assign flag_o  = flag_q;
  assign ready_o = ready_q;

  AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_i |=> (!flag_q && !ready_q)); // R1
  AST_NO_EDGE_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we_i) |-> !edge_hit); // R1
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_OFF) |=> !flag_q); // R8
  AST_CLR_BEATS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !edge_hit) |=> !flag_q); // R9
  AST_READY_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |-> ($past(flag_q) && $past(wait_req_i))); // R11
  AST_READY_AUTOCLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !$past(edge_hit)) |-> !flag_q); // R11
endmodule

// File: rtl/pin_event_detector.sv
module pin_event_detector
  import pin_event_pkg::*;
#(
  parameter int NUM_PINS    = 64,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int CFG_W = MODE_W + IDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                cfg_we_i,
  input  logic [CFG_W-1:0]    cfg_i,
  input  logic                clr_i,
  input  logic                wait_req_i,
  output logic                event_o,
  output logic                wait_ready_o
);
  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [NUM_PINS-1:0] pins_sync;
  logic [IDX_W-1:0]    sel_idx;
  logic                sel_bit;

  pin_sync_bank #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .async_i (pins_i),
    .sync_o  (pins_sync)
  );

  pin_select #(.WIDTH(NUM_PINS)) u_sel (
    .bank_i (pins_sync),
    .idx_i  (sel_idx),
    .bit_o  (sel_bit)
  );

  event_core #(.IDX_W(IDX_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .cfg_we_i   (cfg_we_i),
    .cfg_mode_i (cfg_i[CFG_W-1:IDX_W]),
    .cfg_idx_i  (cfg_i[IDX_W-1:0]),
    .sample_i   (sel_bit),
    .clr_i      (clr_i),
    .wait_req_i (wait_req_i),
    .idx_o      (sel_idx),
    .flag_o     (event_o),
    .ready_o    (wait_ready_o)
  );
endmodule

// File: tb/pin_event_detector_test.sv
module pin_event_detector_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] pins;
  logic        cfg_we;
  logic [8:0]  cfg;
  logic        clr;
  logic        wait_req;
  logic        event_o;
  logic        wait_ready;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pin_event_detector uut (
    .clk (clk), .rst_n (rst_n), .pins_i (pins), .cfg_we_i (cfg_we),
    .cfg_i (cfg), .clr_i (clr), .wait_req_i (wait_req),
    .event_o (event_o), .wait_ready_o (wait_ready)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [2:0] m, input logic [5:0] p);
    cfg_we = 1'b1; cfg = {m, p};
    cyc(1);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_clr();
    clr = 1'b1;
    cyc(1);
    clr = 1'b0;
  endtask

  function automatic logic lvl(input logic [2:0] m, input logic v);
    return m[2] && (v == m[1]);
  endfunction

  function automatic logic edg(input logic [2:0] m, input logic o, input logic n);
    return (m == 3'd1 && !o && n) || (m == 3'd2 && o && !n) || (m == 3'd3 && o != n);
  endfunction

  function automatic string tag(input logic [2:0] m);
    case (m)
      3'd0: return "R8";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4, 3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  // one pin pattern step: detect, then clear and see what re-arms
  task automatic step(input logic [2:0] m, input logic [5:0] p,
                      input logic [63:0] nv, input string extra);
    logic o, n;
    o = pins[p];
    n = nv[p];
    pins = nv;
    cyc(5);
    chk({tag(m), extra}, event_o, lvl(m, o) || edg(m, o, n) || lvl(m, n));
    pulse_clr();
    cyc(5);
    chk({tag(m), " R9 R10 after clear", extra}, event_o, lvl(m, n));
  endtask

  task automatic sweep_case(input logic [2:0] m, input logic [5:0] p);
    pins = '0;
    write_cfg(m, p);
    cyc(5);
    chk({tag(m), " idle"}, event_o, lvl(m, 1'b0));
    pulse_clr();
    cyc(5);
    chk({tag(m), " R9 idle clear"}, event_o, lvl(m, 1'b0));
    step(m, p, 64'd1 << p, " rise");
    step(m, p, 64'd0, " fall");
    step(m, p, ~(64'd1 << p), " R12 other pins");
    step(m, p, 64'd0, " R12 other pins back");
  endtask

  initial begin
    rst_n = 1'b0; pins = '0; cfg_we = 1'b0; cfg = '0; clr = 1'b0; wait_req = 1'b0;
    cyc(3);
    chk("R1 reset flag", event_o, 1'b0);
    chk("R11 reset ready", wait_ready, 1'b0);
    rst_n = 1'b1;
    cyc(4);

    // Sweep: every mode on every pin
    for (int m = 0; m < 8; m++)
      for (int p = 0; p < 64; p++)
        sweep_case(3'(m), 6'(p));

    // R2: exact latency, rising mode on pin 5
    pins = '0;
    write_cfg(3'b001, 6'd5);
    cyc(4);
    pins[5] = 1'b1;
    cyc(1); chk("R2 edge 1", event_o, 1'b0);
    cyc(1); chk("R2 edge 2", event_o, 1'b0);
    cyc(1); chk("R2 edge 3", event_o, 1'b1);
    pulse_clr();
    cyc(4);
    chk("R10 held high no retrigger", event_o, 1'b0);

    // R9: set, clear, set with a held high level
    pins = '0; pins[9] = 1'b1;
    write_cfg(3'b111, 6'd9);
    cyc(5);
    chk("R9 level set", event_o, 1'b1);
    clr = 1'b1;
    cyc(1); chk("R9 clear wins", event_o, 1'b0);
    clr = 1'b0;
    cyc(1); chk("R9 re-set next cycle", event_o, 1'b1);

    // R10: clear in the detection cycle keeps the edge
    pins = '0;
    write_cfg(3'b001, 6'd20);
    cyc(5);
    chk("R10 start clear", event_o, 1'b0);
    pins[20] = 1'b1;
    cyc(2);
    clr = 1'b1;
    cyc(1); chk("R10 edge kept over clear", event_o, 1'b1);
    clr = 1'b0;

    // R1: reconfigure onto a pin already high, no spurious edge
    pins = '0; pins[30] = 1'b1;
    write_cfg(3'b001, 6'd31);
    cyc(5);
    chk("R1 low pin quiet", event_o, 1'b0);
    write_cfg(3'b001, 6'd30);
    cyc(5);
    chk("R1 no edge on reselect", event_o, 1'b0);
    write_cfg(3'b110, 6'd30);
    cyc(4);
    chk("R1 level flag set", event_o, 1'b1);
    cfg_we = 1'b1; cfg = {3'b011, 6'd30};
    cyc(1); cfg_we = 1'b0;
    chk("R1 write clears flag", event_o, 1'b0);
    cyc(4);
    chk("R1 change mode quiet after write", event_o, 1'b0);

    // R11: wait handshake
    pins = '0;
    write_cfg(3'b001, 6'd3);
    cyc(5);
    wait_req = 1'b1;
    pins[3] = 1'b1;
    cyc(2); chk("R11 no ready early", wait_ready, 1'b0);
    cyc(1); chk("R11 flag set", event_o, 1'b1);
    chk("R11 ready not yet", wait_ready, 1'b0);
    cyc(1); chk("R11 ready", wait_ready, 1'b1);
    chk("R11 autoclear", event_o, 1'b0);
    cyc(1); chk("R11 ready one cycle", wait_ready, 1'b0);
    wait_req = 1'b0;
    pins[3] = 1'b0;
    cyc(4);
    pins[3] = 1'b1;
    cyc(5);
    chk("R11 no request flag held", event_o, 1'b1);
    chk("R11 no request no ready", wait_ready, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule